// File: doc/BRIEF.md
# Fixed-Page Descending Byte Stack

This block keeps a last-in-first-out byte stack inside one hard-wired 256-byte page of a 16-bit address space. A client issues push requests carrying a data byte and pop requests. The block turns each request into an address, a write strobe and write data for an external byte-wide synchronous RAM. Popped bytes come back from that RAM one clock after the request. The page number is a build-time constant and cannot be moved at run time.

The stack grows downward. A push stores at the current pointer and then steps the pointer down. A pop steps the pointer up and then reads. A load input sets the starting pointer, and that value also fixes how many entries the stack may hold. Pushing beyond that capacity does not leave the page. The pointer wraps inside it, older bytes are overwritten, and a sticky overflow flag is raised. A pop from an empty stack raises a separate sticky underflow flag. A push and a pop requested in the same cycle are refused and flagged.

Top module: `page_stack`

## Requirements
- R1: The upper byte of `mem_addr_o` is always the page constant (default 8'h01); only the low byte comes from the pointer.
- R2: An accepted push drives `mem_we_o`=1 with address {page, pointer} and `mem_wdata_o`=push byte, then the pointer decreases by one; the first push after reset writes 16'h01FF.
- R3: An accepted pop drives address {page, pointer+1} with `mem_we_o`=0, the pointer increases by one, and the next cycle shows `pop_valid_o`=1 with the RAM byte on `pop_data_o`; `pop_valid_o` is 0 in any other cycle.
- R4: A run of pops returns bytes in the reverse of the order they were pushed.
- R5: `load_i` sets the pointer to `load_ptr_i`, sets the capacity to `load_ptr_i`+1 entries, empties the stack and clears both flags; a push or pop in the same cycle is ignored (no write, pointer takes the loaded value).
- R6: A push while the stack already holds its capacity sets `ovf_o`, which stays 1; the push still writes and the pointer wraps inside the page (8'h00 down to 8'hFF).
- R7: A pop from an empty stack sets `unf_o`, which stays 1; the pointer still increases and wraps inside the page (8'hFF up to 8'h00), reading 16'h0100 in that case.
- R8: `clr_flags_i` clears `ovf_o` and `unf_o` without moving the pointer.
- R9: Push and pop in the same cycle: no write, pointer unchanged, and `err_o` is 1 for exactly the following cycle.
- R10: After reset the pointer is 8'hFF, capacity is 256 entries, and `ovf_o`, `unf_o`, `err_o`, `pop_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load pointer and capacity |
| load_ptr_i | input | 8 | Starting pointer value for a load |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 8 | Byte to push |
| clr_flags_i | input | 1 | Clear overflow and underflow flags |
| mem_addr_o | output | 16 | RAM address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, registered in the RAM |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | Popped byte is valid this cycle |
| sp_o | output | 8 | Current pointer (low address byte) |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| err_o | output | 1 | Conflicting request seen last cycle |

## Verification
On every cycle the checker confirms that the page byte never changes, that each accepted push steps the pointer down and each accepted pop steps it up, that a refused request writes nothing, leaves the pointer alone and pulses the error flag, and that the flags stay set until cleared or reloaded. The bench scenarios show what a single cycle cannot. These are the ordering of returned bytes, the exact point where the capacity is used up under both full and shortened lengths, the overwrite of the oldest byte after a wrap, and the address used by a pop from an empty stack.

// File: rtl/page_stack.sv
module page_stack #(
  parameter int          DW       = 8,
  parameter int          PW       = 8,
  parameter int          HW       = 8,
  parameter logic [7:0]  PAGE     = 8'h01,
  parameter logic [7:0]  RST_PTR  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] load_ptr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          clr_flags_i,
  output logic [HW+PW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic [PW-1:0] sp_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          err_o
);
  localparam logic [HW-1:0] PG = HW'(PAGE);

  logic [PW-1:0] sp_q;
  logic [PW:0]   cap_q, depth_q;
  logic          ovf_q, unf_q, err_q, pv_q;

  wire clash    = push_i & pop_i & ~load_i;
  wire do_push  = push_i & ~pop_i & ~load_i;
  wire do_pop   = pop_i & ~push_i & ~load_i;
  wire full     = depth_q == cap_q;
  wire empty    = depth_q == '0;
  wire [PW-1:0] sp_up = sp_q + 1'b1;

  assign mem_addr_o  = {PG, do_pop ? sp_up : sp_q};
  assign mem_we_o    = do_push;
  assign mem_wdata_o = push_data_i;
  assign pop_data_o  = mem_rdata_i;
  assign pop_valid_o = pv_q;
  assign sp_o        = sp_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign err_o       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= PW'(RST_PTR);
      cap_q   <= {1'b0, PW'(RST_PTR)} + 1'b1;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      err_q   <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      err_q <= clash;
      pv_q  <= do_pop;
      if (load_i) begin
        sp_q    <= load_ptr_i;
        cap_q   <= {1'b0, load_ptr_i} + 1'b1;
        depth_q <= '0;
        ovf_q   <= 1'b0;
        unf_q   <= 1'b0;
      end else begin
        if (clr_flags_i) begin
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end
        if (do_push) begin
          sp_q <= sp_q - 1'b1;
          if (full) ovf_q <= 1'b1;
          else      depth_q <= depth_q + 1'b1;
        end
        if (do_pop) begin
          sp_q <= sp_up;
          if (empty) unf_q <= 1'b1;
          else       depth_q <= depth_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_stack_chk.sv
module page_stack_chk #(
  parameter int         PW   = 8,
  parameter int         HW   = 8,
  parameter logic [7:0] PAGE = 8'h01
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          clr_flags_i,
  input logic [HW+PW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [PW-1:0] sp_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          err_o,
  input logic          pop_valid_o
);
  assert_page_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o[HW+PW-1:PW] == HW'(PAGE));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !load_i) |=> sp_o == $past(sp_o) - 1'b1);

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !load_i) |=> (sp_o == $past(sp_o) + 1'b1) && pop_valid_o);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_flags_i && !load_i) |=> ovf_o);

  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_o && !clr_flags_i && !load_i) |=> unf_o);

  assert_clash_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |-> !mem_we_o);

  assert_clash_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !load_i) |=> $stable(sp_o) && err_o);
endmodule

bind page_stack page_stack_chk #(.PW(PW), .HW(HW), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .push_i(push_i), .pop_i(pop_i),
  .clr_flags_i(clr_flags_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .sp_o(sp_o), .ovf_o(ovf_o), .unf_o(unf_o), .err_o(err_o),
  .pop_valid_o(pop_valid_o)
);

// File: tb/page_stack_bench.sv
module page_stack_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, push = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [7:0] load_ptr = 8'h00, wdat = 8'h00;
  logic [15:0] addr;
  logic we;
  logic [7:0] mwd, mrd, pdat, sp;
  logic pv, ovf, unf, err;
  logic [7:0] ram [256];
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] a_seen;
  logic we_seen;

  always #10 clk = ~clk;

  page_stack u_page_stack (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_ptr_i(load_ptr),
    .push_i(push), .pop_i(pop), .push_data_i(wdat), .clr_flags_i(clr),
    .mem_addr_o(addr), .mem_we_o(we), .mem_wdata_o(mwd), .mem_rdata_i(mrd),
    .pop_data_o(pdat), .pop_valid_o(pv), .sp_o(sp), .ovf_o(ovf),
    .unf_o(unf), .err_o(err)
  );

  always @(posedge clk) begin
    if (we) ram[addr[7:0]] <= mwd;
    mrd <= ram[addr[7:0]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic op(input logic ps, input logic pp, input logic [7:0] d);
    push = ps; pop = pp; wdat = d;
    #1;
    a_seen = addr; we_seen = we;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] p);
    load = 1'b1; load_ptr = p;
    @(negedge clk);
    load = 1'b0;
  endtask

  // {is_pop, data, expected pointer after push / expected popped byte}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h11, 8'hFE}, {1'b0, 8'h22, 8'hFD}, {1'b0, 8'h33, 8'hFC},
    {1'b1, 8'h00, 8'h33}, {1'b0, 8'h44, 8'hFC}, {1'b1, 8'h00, 8'h44},
    {1'b1, 8'h00, 8'h22}, {1'b1, 8'h00, 8'h11}
  };

  initial begin
    logic [7:0] msp;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 sp", {8'h0, sp}, 16'h00FF);
    chk("R10 flags", {12'h0, ovf, unf, err, pv}, 16'h0);

    msp = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      if (!VEC[i][16]) begin
        op(1'b1, 1'b0, VEC[i][15:8]);
        chk("R2 push addr", a_seen, {8'h01, msp});
        chk("R2 push we", {15'h0, we_seen}, 16'h1);
        chk("R2 sp after push", {8'h0, sp}, {8'h0, VEC[i][7:0]});
        msp = msp - 1'b1;
      end else begin
        op(1'b0, 1'b1, 8'h00);
        chk("R3 pop addr", a_seen, {8'h01, msp + 8'h01});
        chk("R3 pop valid", {15'h0, pv}, 16'h1);
        chk("R4 pop data", {8'h0, pdat}, {8'h0, VEC[i][7:0]});
        msp = msp + 1'b1;
      end
    end
    @(negedge clk);
    chk("R3 valid drops", {15'h0, pv}, 16'h0);

    // R6 overflow at full length
    do_load(8'hFF);
    for (int i = 0; i < 256; i++) op(1'b1, 1'b0, 8'(i));
    chk("R6 no ovf at capacity", {15'h0, ovf}, 16'h0);
    chk("R6 sp after 256", {8'h0, sp}, 16'h00FF);
    op(1'b1, 1'b0, 8'hA5);
    chk("R6 wrap addr", a_seen, 16'h01FF);
    chk("R6 ovf set", {15'h0, ovf}, 16'h1);
    op(1'b0, 1'b1, 8'h00);
    chk("R6 overwritten byte", {8'h0, pdat}, 16'h00A5);
    @(negedge clk);
    chk("R6 ovf sticky", {15'h0, ovf}, 16'h1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 ovf cleared", {15'h0, ovf}, 16'h0);
    chk("R8 sp kept", {8'h0, sp}, 16'h00FF);

    // R5 shortened length
    do_load(8'h03);
    chk("R5 loaded sp", {8'h0, sp}, 16'h0003);
    for (int i = 0; i < 4; i++) op(1'b1, 1'b0, 8'h70 + 8'(i));
    chk("R5 cap 4 no ovf", {15'h0, ovf}, 16'h0);
    op(1'b1, 1'b0, 8'h7F);
    chk("R5 R6 ovf at 5th", {15'h0, ovf}, 16'h1);
    chk("R6 5th addr", a_seen, 16'h01FF);
    do_load(8'h10);
    chk("R5 load clears ovf", {15'h0, ovf}, 16'h0);
    // load beats push
    load = 1'b1; load_ptr = 8'h40; push = 1'b1; wdat = 8'hEE;
    #1; we_seen = we;
    @(negedge clk); load = 1'b0; push = 1'b0;
    chk("R5 push ignored on load", {15'h0, we_seen}, 16'h0);
    chk("R5 sp on load", {8'h0, sp}, 16'h0040);

    // R7 underflow
    do_load(8'hFF);
    op(1'b0, 1'b1, 8'h00);
    chk("R7 empty pop addr", a_seen, 16'h0100);
    chk("R7 unf set", {15'h0, unf}, 16'h1);
    chk("R7 sp wrap", {8'h0, sp}, 16'h0000);
    @(negedge clk);
    chk("R7 unf sticky", {15'h0, unf}, 16'h1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 unf cleared", {15'h0, unf}, 16'h0);

    // R9 conflict
    op(1'b1, 1'b1, 8'h99);
    chk("R9 no write", {15'h0, we_seen}, 16'h0);
    chk("R9 err pulse", {15'h0, err}, 16'h1);
    chk("R9 sp held", {8'h0, sp}, 16'h0000);
    @(negedge clk);
    chk("R9 err one cycle", {15'h0, err}, 16'h0);
    chk("R1 page", {8'h0, addr[15:8]}, 16'h0001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule